// File: doc/BRIEF.md
# Narrow-to-Wide Handshake Bridge

The bridge joins a producer that emits narrow words to a consumer that reads wide words, when the two sides follow different handshakes. The producer raises a request and expects an acknowledge on the cycle that follows. It then writes one narrow word per cycle for as long as a continuation signal stays high. The consumer sees a forwarded request and answers it. It then waits for a data-ready strobe and takes one wide word on each strobe. Neither side drives the continuation signal or the data-ready strobe, so the bridge generates both.

Inside, a packing buffer of `BUF_K` bits collects producer words starting from the least significant slot. A scaled occupancy counter tracks how full it is. Let x = floor(BUF_K/P_W) and y = floor(BUF_K/C_W). Every accepted write adds y to the counter and every consumer read subtracts x. The counter is confined to the range 0 to x·y. Any event that would leave that range is blocked. The buffer is always filled completely before it is drained, and drained completely before it is filled again. With the defaults (8-bit producer, 16-bit consumer, `BUF_K` = 16), x = 2 and y = 1: two writes fill the buffer and one read empties it.

Top module: `wbr_bridge`

## Requirements
- R1: When the bridge is idle and `p_req_i` is high at a clock edge, `p_ack_o` is high for exactly the one following cycle.
- R2: `c_req_o` rises only on the cycle after `p_req_i` was high. It then stays high until the consumer's `c_ack_i` has been seen at a clock edge, and it is low while the buffer fills.
- R3: `p_more_o` rises only after `c_ack_i` has been seen. Before that, any `p_wr_i` pulse is dropped and leaves no trace in the data the consumer later reads.
- R4: Each accepted write raises the occupancy by y, and each read lowers it by x. Occupancy never leaves the range 0 to x·y, and a write strobe outside the fill phase (for example, during the drain) is dropped.
- R5: `p_more_o` and `c_rdy_o` are never high together. `c_rdy_o` first rises only when occupancy equals x·y, which with the defaults is two writes after `p_more_o` rose. `p_more_o` stays high, with `c_rdy_o` low, across idle gaps in the middle of a fill.
- R6: Producer word k, counted from 0 in the order it was accepted, lands at bits [k·P_W +: P_W] of the packed buffer. While `c_rdy_o` is high on drain cycle j, `c_data_o` equals bits [j·C_W +: C_W]. With the defaults, `c_data_o` = {word1, word0}.
- R7: `c_rdy_o` is high for exactly y consecutive cycles per fill (one with the defaults). Afterwards the bridge is idle and `c_data_o` reads 0.
- R8: Priority: in idle, a request wins over a simultaneous write strobe, and the write is dropped. If `c_ack_i` is already present in the acknowledge cycle, the bridge goes straight to filling, and `p_more_o` is high on the next cycle.
- R9: A synchronous active-high `rst` returns the bridge to idle. The counter goes to 0, the buffer is cleared, `p_ack_o`, `p_more_o`, `c_req_o` and `c_rdy_o` are low, and `c_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p_req_i | input | 1 | Producer request |
| p_wr_i | input | 1 | Producer write strobe |
| p_data_i | input | P_W | Producer write word |
| p_ack_o | output | 1 | Acknowledge to producer, one cycle after request |
| p_more_o | output | 1 | Generated continuation signal to producer |
| c_ack_i | input | 1 | Consumer acknowledge of forwarded request |
| c_req_o | output | 1 | Request forwarded to consumer |
| c_rdy_o | output | 1 | Generated data-ready strobe to consumer |
| c_data_o | output | C_W | Wide word presented to consumer |

## Verification
The assertions assume that the producer writes only in answer to `p_more_o`, and that the consumer acknowledges only after it has seen `c_req_o`. The consumer takes a word on every cycle in which `c_rdy_o` is high, with no stall. The stimulus breaks the first assumption on purpose: it sends stray write strobes while a request is pending, in idle together with a request, and during the drain, because the bridge must drop them. Random gaps inside a fill and random consumer acknowledge delays of zero to three cycles stay within the other two assumptions.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_WAIT,
        ST_FILL,
        ST_DRAIN
    } bstate_e;

    typedef struct packed {
        logic ack;
        logic creq;
        logic fill;
        logic drain;
    } ctrl_t;

    function automatic int gcd_f(int a, int b);
        int ta;
        int tb;
        int tr;
        ta = a;
        tb = b;
        while (tb != 0) begin
            tr = ta % tb;
            ta = tb;
            tb = tr;
        end
        return ta;
    endfunction

    function automatic int lcm_f(int a, int b);
        return (a / gcd_f(a, b)) * b;
    endfunction

    function automatic int max_f(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wbr_ctrl.sv
module wbr_ctrl
    import wbr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  p_req,
    input  logic  c_ack,
    input  logic  last_wr,
    input  logic  last_rd,
    output ctrl_t ctl
);
    bstate_e st_q;
    bstate_e st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (p_req) st_d = ST_ACK;
            ST_ACK:   st_d = c_ack ? ST_FILL : ST_WAIT;
            ST_WAIT:  if (c_ack) st_d = ST_FILL;
            ST_FILL:  if (last_wr) st_d = ST_DRAIN;
            ST_DRAIN: if (last_rd) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        ctl.ack   = (st_q == ST_ACK);
        ctl.creq  = (st_q == ST_ACK) || (st_q == ST_WAIT);
        ctl.fill  = (st_q == ST_FILL);
        ctl.drain = (st_q == ST_DRAIN);
    end

    assert_one_phase_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.ack, ctl.fill, ctl.drain}));
    assert_fill_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.fill) |-> $past(c_ack));
endmodule

// File: rtl/wbr_occ.sv
module wbr_occ #(
    parameter int UP    = 1,
    parameter int DN    = 2,
    parameter int LIMIT = 2,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_req,
    input  logic             rd_req,
    output logic [CNT_W-1:0] count,
    output logic             wr_ok,
    output logic             rd_ok,
    output logic             last_wr,
    output logic             last_rd
);
    localparam logic [CNT_W:0] LIM_V = (CNT_W + 1)'(LIMIT);
    localparam logic [CNT_W:0] UP_V  = (CNT_W + 1)'(UP);
    localparam logic [CNT_W:0] DN_V  = (CNT_W + 1)'(DN);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum_up;
    logic             wr_go;
    logic             rd_go;

    assign sum_up  = {1'b0, cnt_q} + UP_V;
    assign wr_ok   = (sum_up <= LIM_V);
    assign rd_ok   = ({1'b0, cnt_q} >= DN_V);
    assign wr_go   = wr_req && wr_ok;
    assign rd_go   = rd_req && rd_ok;
    assign last_wr = wr_go && (sum_up == LIM_V);
    assign last_rd = rd_go && ({1'b0, cnt_q} == DN_V);
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case ({wr_go, rd_go})
                2'b10:   cnt_q <= cnt_q + CNT_W'(UP);
                2'b01:   cnt_q <= cnt_q - CNT_W'(DN);
                2'b11:   cnt_q <= cnt_q + CNT_W'(UP) - CNT_W'(DN);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        {1'b0, cnt_q} <= LIM_V);
    assert_step_up_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_ok && !rd_req) |=> (cnt_q == $past(cnt_q) + CNT_W'(UP)));
    assert_step_dn_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_ok && !wr_req) |=> (cnt_q == $past(cnt_q) - CNT_W'(DN)));
endmodule

// File: rtl/wbr_pack.sv
module wbr_pack #(
    parameter int PW = 8,
    parameter int CW = 16,
    parameter int XS = 2,
    parameter int BW = 16,
    localparam int IDX_W = $clog2(XS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [PW-1:0] wdata,
    input  logic          rd,
    input  logic          clr,
    output logic [CW-1:0] rdata
);
    logic [BW-1:0]    buf_q;
    logic [BW-1:0]    buf_wr;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        buf_wr = buf_q;
        for (int k = 0; k < XS; k++) begin
            if (idx_q == IDX_W'(k)) buf_wr[k*PW +: PW] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            buf_q <= '0;
            idx_q <= '0;
        end else if (wr) begin
            buf_q <= buf_wr;
            idx_q <= idx_q + 1'b1;
        end else if (rd) begin
            buf_q <= buf_q >> CW;
        end
    end

    assign rdata = buf_q[CW-1:0];

    assert_slot_range_R6: assert property (@(posedge clk) disable iff (rst)
        wr |-> (idx_q < IDX_W'(XS)));
    assert_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (buf_q == '0));
endmodule

// File: rtl/wbr_bridge.sv
module wbr_bridge
    import wbr_pkg::*;
#(
    parameter int P_W   = 8,
    parameter int C_W   = 16,
    parameter int BUF_K = wbr_pkg::lcm_f(P_W, C_W)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           p_req_i,
    input  logic           p_wr_i,
    input  logic [P_W-1:0] p_data_i,
    output logic           p_ack_o,
    output logic           p_more_o,
    input  logic           c_ack_i,
    output logic           c_req_o,
    output logic           c_rdy_o,
    output logic [C_W-1:0] c_data_o
);
    localparam int XS    = BUF_K / P_W;
    localparam int YS    = BUF_K / C_W;
    localparam int LIMIT = XS * YS;
    localparam int BW    = wbr_pkg::max_f(XS * P_W, YS * C_W);
    localparam int CNT_W = $clog2(LIMIT + 1);

    initial begin
        assert (XS >= 1 && YS >= 1)
            else $error("buffer capacity smaller than a word");
    end

    ctrl_t            ctl;
    logic [CNT_W-1:0] occ;
    logic             wr_ok;
    logic             rd_ok;
    logic             last_wr;
    logic             last_rd;
    logic             wr_req;
    logic             wr_take;

    assign wr_req  = ctl.fill && p_wr_i;
    assign wr_take = wr_req && wr_ok;

    wbr_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .p_req   (p_req_i),
        .c_ack   (c_ack_i),
        .last_wr (last_wr),
        .last_rd (last_rd),
        .ctl     (ctl)
    );

    wbr_occ #(.UP(YS), .DN(XS), .LIMIT(LIMIT)) u_occ (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .rd_req  (ctl.drain),
        .count   (occ),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .last_wr (last_wr),
        .last_rd (last_rd)
    );

    wbr_pack #(.PW(P_W), .CW(C_W), .XS(XS), .BW(BW)) u_pack (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_take),
        .wdata (p_data_i),
        .rd    (c_rdy_o),
        .clr   (last_rd),
        .rdata (c_data_o)
    );

    assign p_ack_o  = ctl.ack;
    assign c_req_o  = ctl.creq;
    assign p_more_o = ctl.fill && wr_ok;
    assign c_rdy_o  = ctl.drain && rd_ok;

    assert_ack_after_req_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(p_ack_o) |-> $past(p_req_i));
    assert_ack_single_R1: assert property (@(posedge clk) disable iff (rst)
        p_ack_o |=> !p_ack_o);
    assert_creq_after_req_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(c_req_o) |-> $past(p_req_i));
    assert_more_after_cack_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(p_more_o) |-> $past(c_ack_i));
    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
        !(p_more_o && c_rdy_o));
    assert_drain_when_full_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(c_rdy_o) |-> (occ == CNT_W'(LIMIT)));
    assert_last_read_R7: assert property (@(posedge clk) disable iff (rst)
        (c_rdy_o && occ == CNT_W'(XS)) |=> !c_rdy_o);
    assert_reset_idle_R9: assert property (@(posedge clk)
        rst |=> (!p_ack_o && !p_more_o && !c_req_o && !c_rdy_o && occ == '0));
endmodule

// File: tb/tb_wbr_bridge.sv
`timescale 1ns/1ps
module tb_wbr_bridge;
    localparam int PW = 8;
    localparam int CW = 16;

    function automatic int tb_gcd(int a, int b);
        int ta;
        int tb;
        int tr;
        ta = a;
        tb = b;
        while (tb != 0) begin
            tr = ta % tb;
            ta = tb;
            tb = tr;
        end
        return ta;
    endfunction

    localparam int KB = (PW / tb_gcd(PW, CW)) * CW;
    localparam int XS = KB / PW;
    localparam int YS = KB / CW;

    logic          clk = 1'b0;
    logic          rst;
    logic          p_req_i;
    logic          p_wr_i;
    logic [PW-1:0] p_data_i;
    logic          p_ack_o;
    logic          p_more_o;
    logic          c_ack_i;
    logic          c_req_o;
    logic          c_rdy_o;
    logic [CW-1:0] c_data_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    wbr_bridge #(.P_W(PW), .C_W(CW)) dut (
        .clk      (clk),
        .rst      (rst),
        .p_req_i  (p_req_i),
        .p_wr_i   (p_wr_i),
        .p_data_i (p_data_i),
        .p_ack_o  (p_ack_o),
        .p_more_o (p_more_o),
        .c_ack_i  (c_ack_i),
        .c_req_o  (c_req_o),
        .c_rdy_o  (c_rdy_o),
        .c_data_o (c_data_o)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] pack_words(input logic [PW-1:0] w [XS]);
        logic [255:0] v;
        v = '0;
        for (int k = 0; k < XS; k++) v[k*PW +: PW] = w[k];
        return v;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic run_txn(input int t);
        logic [PW-1:0] words [XS];
        logic [255:0]  exp;
        int            ack_d;
        for (int k = 0; k < XS; k++) words[k] = PW'($urandom);
        exp   = pack_words(words);
        ack_d = (t % 5 == 0) ? 0 : int'($urandom % 4);

        // R8: request with simultaneous stray write in idle
        p_req_i  = 1'b1;
        p_wr_i   = (t % 2 == 1);
        p_data_i = 8'hEE;
        step();
        check("R1", "ack after request", 64'(p_ack_o), 64'd1);
        check("R2", "request forwarded", 64'(c_req_o), 64'd1);
        check("R3", "more before consumer ack", 64'(p_more_o), 64'd0);
        p_req_i = 1'b0;
        p_wr_i  = 1'b0;
        if (ack_d == 0) begin
            // R8: consumer ack already in the acknowledge cycle
            c_ack_i = 1'b1;
            step();
            c_ack_i = 1'b0;
        end else begin
            p_wr_i   = 1'b1;
            p_data_i = 8'hA5;
            step();
            check("R1", "ack single cycle", 64'(p_ack_o), 64'd0);
            check("R2", "request held", 64'(c_req_o), 64'd1);
            check("R3", "stray write no more", 64'(p_more_o), 64'd0);
            for (int d = 1; d < ack_d; d++) begin
                step();
                check("R2", "request held waiting", 64'(c_req_o), 64'd1);
            end
            p_wr_i  = 1'b0;
            c_ack_i = 1'b1;
            step();
            c_ack_i = 1'b0;
        end
        check(ack_d == 0 ? "R8" : "R3", "more after consumer ack", 64'(p_more_o), 64'd1);
        check("R2", "request dropped in fill", 64'(c_req_o), 64'd0);

        for (int k = 0; k < XS; k++) begin
            int gaps;
            gaps = int'($urandom % 3);
            for (int g = 0; g < gaps; g++) begin
                p_wr_i = 1'b0;
                step();
                check("R5", "more held over gap", 64'(p_more_o), 64'd1);
                check("R5", "no ready in fill", 64'(c_rdy_o), 64'd0);
            end
            p_wr_i   = 1'b1;
            p_data_i = words[k];
            step();
            p_wr_i = 1'b0;
            if (k < XS - 1) begin
                check("R5", "no ready before full", 64'(c_rdy_o), 64'd0);
                check("R5", "more while filling", 64'(p_more_o), 64'd1);
            end
        end

        for (int j = 0; j < YS; j++) begin
            check("R5", "ready when full", 64'(c_rdy_o), 64'd1);
            check("R5", "more low in drain", 64'(p_more_o), 64'd0);
            check("R6", "packed word", 64'(c_data_o), 64'(exp[j*CW +: CW]));
            // R4: stray write during drain must be dropped
            p_wr_i   = 1'b1;
            p_data_i = 8'h3C;
            step();
        end
        p_wr_i = 1'b0;
        check("R7", "ready ended", 64'(c_rdy_o), 64'd0);
        check("R7", "buffer cleared", 64'(c_data_o), 64'd0);
        check("R4", "idle after drain", 64'(p_more_o), 64'd0);
        step();
    endtask

    initial begin
        void'($urandom(32'd1357));
        rst      = 1'b1;
        p_req_i  = 1'b0;
        p_wr_i   = 1'b0;
        p_data_i = '0;
        c_ack_i  = 1'b0;
        repeat (3) step();
        check("R9", "ack in reset", 64'(p_ack_o), 64'd0);
        check("R9", "more in reset", 64'(p_more_o), 64'd0);
        check("R9", "creq in reset", 64'(c_req_o), 64'd0);
        check("R9", "rdy in reset", 64'(c_rdy_o), 64'd0);
        check("R9", "data in reset", 64'(c_data_o), 64'd0);
        rst = 1'b0;
        step();

        for (int t = 0; t < 40; t++) run_txn(t);

        // R9: reset in the middle of a fill
        p_req_i = 1'b1;
        step();
        p_req_i = 1'b0;
        c_ack_i = 1'b1;
        step();
        c_ack_i  = 1'b0;
        p_wr_i   = 1'b1;
        p_data_i = 8'h77;
        step();
        p_wr_i = 1'b0;
        rst    = 1'b1;
        step();
        check("R9", "more after mid reset", 64'(p_more_o), 64'd0);
        check("R9", "rdy after mid reset", 64'(c_rdy_o), 64'd0);
        check("R9", "data after mid reset", 64'(c_data_o), 64'd0);
        rst = 1'b0;
        step();
        for (int t = 40; t < 44; t++) run_txn(t);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule